// File: doc/BRIEF.md
# Sampled-Result Serial Output Port

This block is the read-only serial output of a sampling data converter. A master selects it with an active-low select line and drives a serial clock that rests high between transfers. When select goes low, the block captures a 12-bit parallel result and frames it as a 16-bit word: four zero bits on top, then the result with its most significant bit first. The block then presents that word one bit at a time on a single data line.

The first bit, which is a zero, appears as soon as select falls. No clock edge is needed for it. Each falling clock edge after that does two things. The master samples the bit that is on the line, and the port then replaces it with the next bit. A full word therefore takes exactly 16 falling edges, and no dummy clock is needed.

Select and clock arrive from outside and are sampled by the block's system clock. The block detects their edges internally and updates its outputs from registers. Because of this, the data line changes only after the synchronizer delay has passed. A receiver that samples on a falling clock edge still sees the bit that was there before that edge.

Top module: `conv_sdo_shifter`

## Requirements
- R1: While reset is high and in the cycle after it, the output enable is 0 and the data line is 0.
- R2: While select is high, the output enable is 0 and the data line is 0. Serial clock edges arriving in that time change neither output.
- R3: Within three system-clock cycles after select goes low, the output enable becomes 1 and the first frame bit (0) is on the data line. No serial clock edge is needed for this.
- R4: The frame is {4'b0000, result[11:0]}, sent from frame bit 15 down to frame bit 0. The result is captured when select falls. After k falling clock edges (k in 0..15), frame bit 15-k is on the data line.
- R5: Frame bit 0 (result bit 0) is on the line after the 15th falling edge. The receiver's 16th falling edge delivers it. No extra clock cycle is inserted before the first bit.
- R6: Falling clock edges after the 16th, while select stays low, keep the data line at 0.
- R7: One system-clock cycle after a falling serial clock edge, the data line still holds the bit that was present before that edge. The new bit appears within four cycles of the edge.
- R8: If select rises before the frame is complete, the transfer is abandoned and the outputs go idle. The next select fall starts a new frame from bit 15, using the result present at that fall.
- R9: While select stays low, the output enable stays 1. The internal bit count grows by one per falling edge and never goes past 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the master |
| sclk | input | 1 | Serial clock from the master, rests high |
| result | input | 12 | Parallel conversion result, captured when select falls |
| sdo | output | 1 | Serial data line |
| sdo_oe | output | 1 | Output enable for the data line pad; 0 means high impedance |

## Verification
An edge on select or on the serial clock passes through two sampling flops and one edge-detect flop before the output register updates. Its effect therefore reaches the pins in the third cycle after the edge. The bench changes inputs on falling system-clock edges, waits four rising edges, and then samples on a falling edge. At that point every result from R2 to R6 and R8 is due. For R7, the bench samples after a single rising edge and expects the old bit, since the shift cannot have landed yet. A sweep of walking-one and arithmetic result words compares every frame position, and the zero tail after it, against {4'b0, result} computed in the bench.

// File: rtl/conv_sdo_pkg.sv
package conv_sdo_pkg;
  // Transfer phase of the output shifter
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // select high, line released
    PH_SHIFT = 2'd1,  // frame bits still pending
    PH_TAIL  = 2'd2   // all frame bits sent, zeros follow
  } sdo_phase_e;
endpackage

// File: rtl/sdo_edge_sync.sv
module sdo_edge_sync #(
  parameter int  STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic fell
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE_LVL;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE_LVL}};
        else     chain <= {chain[LAST-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE_LVL;
    else     prev <= chain[LAST];
  end

  assign level = chain[LAST];
  assign fell  = prev & ~chain[LAST];
endmodule

// File: rtl/sdo_frame_shift.sv
module sdo_frame_shift
  import conv_sdo_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_high,
  input  logic             sel_fell,
  input  logic             sck_fell,
  input  logic [RES_W-1:0] result,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [CNT_W-1:0] bit_cnt,
  output sdo_phase_e       phase
);
  localparam int FRAME_W = RES_W + LEAD_W;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] frame_q;
  logic               oe_q;

  always_ff @(posedge clk) begin
    if (rst || sel_high) begin
      frame_q <= '0;
      oe_q    <= 1'b0;
      bit_cnt <= '0;
      phase   <= PH_IDLE;
    end else if (sel_fell) begin
      frame_q <= {{LEAD_W{1'b0}}, result};
      oe_q    <= 1'b1;
      bit_cnt <= '0;
      phase   <= PH_SHIFT;
    end else if (sck_fell && phase != PH_IDLE) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      if (bit_cnt != FULL_CNT) bit_cnt <= bit_cnt + 1'b1;
      if (phase == PH_SHIFT && bit_cnt == LAST_CNT) phase <= PH_TAIL;
    end
  end

  assign sdo    = frame_q[FRAME_W-1];
  assign sdo_oe = oe_q;
endmodule

// File: rtl/conv_sdo_shifter.sv
module conv_sdo_shifter
  import conv_sdo_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int LEAD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] result,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int FRAME_W = RES_W + LEAD_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic             cs_lvl, cs_fell;
  logic             sck_lvl, sck_fell;
  logic [CNT_W-1:0] bit_cnt;
  sdo_phase_e       phase;

  sdo_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .async_in(cs_n), .level(cs_lvl), .fell(cs_fell)
  );

  sdo_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sck_sync (
    .clk(clk), .rst(rst), .async_in(sclk), .level(sck_lvl), .fell(sck_fell)
  );

  sdo_frame_shift #(.RES_W(RES_W), .LEAD_W(LEAD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst),
    .sel_high(cs_lvl), .sel_fell(cs_fell), .sck_fell(sck_fell),
    .result(result),
    .sdo(sdo), .sdo_oe(sdo_oe),
    .bit_cnt(bit_cnt), .phase(phase)
  );

  logic unused_ok;
  assign unused_ok = sck_lvl;
endmodule

// File: rtl/conv_sdo_shifter_chk.sv
module conv_sdo_shifter_chk #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             sclk,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [CNT_W-1:0] bit_cnt
);
  logic [2:0] age;
  logic       warm;
  logic       rst_d = 1'b0;

  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign warm = (age >= 3'd5);

  // R1: outputs idle in the cycle after reset was high
  always @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_idle: assert (!sdo_oe && !sdo);
    end
    rst_d <= rst;
  end

  // R2: select held high for three cycles releases the line
  a_r2_released_when_idle: assert property (@(posedge clk) disable iff (rst)
    (warm && cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> (!sdo_oe && !sdo));

  // R9: select held low long enough keeps the line driven
  a_r9_driven_when_selected: assert property (@(posedge clk) disable iff (rst)
    (warm && !cs_n && !$past(cs_n, 1) && !$past(cs_n, 2) && !$past(cs_n, 3)
       && !$past(cs_n, 4)) |-> sdo_oe);

  // R6: once a full frame has gone out, only zeros follow
  a_r6_zero_tail: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && bit_cnt == CNT_W'(FRAME_W)) |-> !sdo);

  // R9: bit count steps by one, restarts at zero, never passes the frame length
  a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
    (warm && bit_cnt != $past(bit_cnt))
      |-> (bit_cnt == '0 || bit_cnt == $past(bit_cnt) + 1'b1));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(FRAME_W));

  // R7: with clock and select quiet for several cycles, the line holds its bit
  a_r7_hold_while_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm && !cs_n && !$past(cs_n, 1) && !$past(cs_n, 2) && !$past(cs_n, 3)
       && !$past(cs_n, 4) && $past(sclk, 1) && $past(sclk, 2) && $past(sclk, 3))
      |-> $stable(sdo));
endmodule

bind conv_sdo_shifter conv_sdo_shifter_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
  .sdo(sdo), .sdo_oe(sdo_oe), .bit_cnt(bit_cnt)
);

// File: tb/conv_sdo_shifter_bench.sv
module conv_sdo_shifter_bench;
  localparam int RES_W   = 12;
  localparam int LEAD_W  = 4;
  localparam int FRAME_W = RES_W + LEAD_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cs_n = 1'b1;
  logic             sclk = 1'b1;
  logic [RES_W-1:0] result = '0;
  logic             sdo, sdo_oe;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  conv_sdo_shifter #(.RES_W(RES_W), .LEAD_W(LEAD_W)) u_conv_sdo_shifter (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .result(result),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [RES_W-1:0] r, input int falls);
    logic [FRAME_W-1:0] fr;
    fr = {{LEAD_W{1'b0}}, r};
    if (falls >= FRAME_W) return 1'b0;
    return fr[FRAME_W-1-falls];
  endfunction

  // One falling edge then back high; checks old bit right after, new bit later
  task automatic clock_fall(input logic [RES_W-1:0] r, input int falls_before);
    sclk = 1'b0;
    @(posedge clk); @(negedge clk);
    check(sdo == exp_bit(r, falls_before), "R7 old bit held after edge",
          sdo, exp_bit(r, falls_before));
    repeat (3) @(posedge clk);
    @(negedge clk);
    sclk = 1'b1;
    settle();
  endtask

  task automatic run_frame(input logic [RES_W-1:0] r, input int extra);
    result = r;
    @(negedge clk);
    cs_n = 1'b0;
    settle();
    check(sdo_oe == 1'b1, "R3 enable after select fall", sdo_oe, 1);
    check(sdo == 1'b0, "R3 first bit without clock", sdo, 0);
    for (int k = 0; k < FRAME_W + extra; k++) begin
      if (k < FRAME_W)
        check(sdo == exp_bit(r, k), (k == FRAME_W - 1) ? "R5 last bit after 15 edges" : "R4 frame bit",
              sdo, exp_bit(r, k));
      else
        check(sdo == 1'b0, "R6 zero tail", sdo, 0);
      check(sdo_oe == 1'b1, "R9 enable held", sdo_oe, 1);
      clock_fall(r, k);
    end
    check(sdo == 1'b0, "R6 zero after frame", sdo, 0);
    cs_n = 1'b1;
    settle();
    check(sdo_oe == 1'b0, "R2 released after frame", sdo_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sdo_oe == 1'b0, "R1 reset enable", sdo_oe, 0);
    check(sdo == 1'b0, "R1 reset data", sdo, 0);
    rst = 1'b0;
    settle();
    check(sdo_oe == 1'b0, "R1 idle after reset", sdo_oe, 0);

    // R2: clocks while deselected are ignored
    result = 12'hFFF;
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; settle();
      check(sdo_oe == 1'b0 && sdo == 1'b0, "R2 clock ignored while deselected", {sdo_oe, sdo}, 0);
      sclk = 1'b1; settle();
    end

    // R4/R5/R6 sweep: special words, walking ones, arithmetic words
    run_frame(12'hFFF, 3);
    run_frame(12'h000, 1);
    run_frame(12'hA5A, 1);
    run_frame(12'h5A5, 0);
    for (int b = 0; b < RES_W; b++) run_frame(RES_W'(1) << b, 1);
    for (int j = 1; j <= 8; j++) run_frame(RES_W'(j * 337 + 91), 2);

    // R8: abort mid-frame then a clean frame
    result = 12'hFFF;
    @(negedge clk); cs_n = 1'b0; settle();
    for (int k = 0; k < 6; k++) clock_fall(12'hFFF, k);
    check(sdo == 1'b1, "R8 mid-frame bit before abort", sdo, 1);
    cs_n = 1'b1; settle();
    check(sdo_oe == 1'b0 && sdo == 1'b0, "R8 abort releases line", {sdo_oe, sdo}, 0);
    run_frame(12'h9C3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule